// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers up to 32 interrupt source lines into one bank. Each line has its own configuration word. The word sets the line's priority, chooses rising-edge or level sensitivity, and routes the line either to the normal request output or to the fast request output. Source activity is captured in a pending vector and filtered by a per-line mask. The unmasked pending lines then go through two priority arbiters, one for each output.

When an output has no source in service, the winner of its arbiter is latched as that output's current source. The output then raises its request. The source number stays fixed while software services it, and a higher-priority arrival does not replace it. Software releases the source by writing an acknowledge bit in the control word. One cycle later, arbitration runs again.

A global gate blocks both outputs until software opens it. Source numbers are reported as bank index times 32 plus line index. Only bank 0 may route lines to the fast output.

Top module: `intc_bank`

## Requirements
- R1: After reset the mask word (0x04) reads all ones, the global gate (0x14, bit 0) reads 1, both request outputs are low, and both source-number words read 0.
- R2: A mask bit of 1 blocks its line from arbitration and from the outputs, while its pending bit still records activity. A mask bit of 0 enables the line.
- R3: Each line's configuration word sits at 0x80 + 4 × line and reads back as written. Bit 0 selects fast routing, bit 1 selects the trigger (1 = level, 0 = rising edge), and bits 6:2 hold the priority.
- R4: Fast routing exists only when the bank index is 0. In any other bank, bit 0 of every configuration word stores and reads 0, the line goes to the normal output, and the fast output never rises.
- R5: The pending bit of a level line follows its input, one cycle late. The pending bit of an edge line is set on a 0-to-1 input change and stays set until that source is acknowledged. A steady high input does not set it again.
- R6: A write to the pending word (0x00) ANDs the edge-line pending bits with the written data, so writing zero clears them all.
- R7: Among candidate lines, the lowest priority value wins. On equal priority, the lower line index wins.
- R8: A latched source stays fixed until an acknowledge write to the control word (0x10): bit 0 releases the normal source and bit 1 releases the fast source. The request is low in the cycle after the write, and a new winner is latched on the following cycle.
- R9: The normal (0x08) and fast (0x0C) source-number words read bank × 32 + line while a source is latched, and 0 otherwise.
- R10: A request output is high only while its latched source is still pending and unmasked and the global gate is 0. With no active line, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on address) |
| norm_irq | output | 1 | Normal interrupt request |
| fast_irq | output | 1 | Fast interrupt request |

## Verification
The assertions check four properties on every cycle:
- a latched source number does not change without an acknowledge;
- a request never names a masked line;
- both outputs stay quiet when nothing is active;
- a level line's pending bit equals the previous input, and a non-zero bank never raises the fast output.

Only the bench scenarios can show the following:
- the arbitration order (priority first, then index);
- the one-cycle gap after an acknowledge;
- the way an edge line is not re-armed while its input stays high;
- the clearing of pending bits through a register write;
- the bank-offset numbering.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    // Register byte offsets
    localparam int unsigned OFF_PEND  = 32'h00;
    localparam int unsigned OFF_MASK  = 32'h04;
    localparam int unsigned OFF_NSRC  = 32'h08;
    localparam int unsigned OFF_FSRC  = 32'h0C;
    localparam int unsigned OFF_CTRL  = 32'h10;
    localparam int unsigned OFF_GATE  = 32'h14;
    localparam int unsigned OFF_LVL   = 32'h80;
    // Configuration word fields
    localparam int unsigned CFG_FAST  = 0;
    localparam int unsigned CFG_LEVEL = 1;
    localparam int unsigned CFG_PRIO  = 2;
    // Control word bits
    localparam int unsigned ACK_NORM  = 0;
    localparam int unsigned ACK_FAST  = 1;
endpackage

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter #(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 5,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0]             req,
    input  logic [N_LINES-1:0][PRIO_W-1:0] prio,
    output logic                           found,
    output logic [IDX_W-1:0]               win_idx
);
    logic [PRIO_W-1:0] best;

    // Strict less-than keeps the lower index on a tie.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        best    = '1;
        for (int i = 0; i < N_LINES; i++) begin
            if (req[i] && (!found || prio[i] < best)) begin
                found   = 1'b1;
                best    = prio[i];
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_channel.sv
`timescale 1ns/1ps
module intc_channel #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             cand_ok,
    input  logic [IDX_W-1:0] cand_idx,
    output logic             held,
    output logic [IDX_W-1:0] held_idx
);
    typedef struct packed {
        logic             held;
        logic [IDX_W-1:0] idx;
    } ch_t;

    ch_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.held) begin
            if (ack) nxt_d.held = 1'b0;
        end else if (cand_ok) begin
            nxt_d.held = 1'b1;
            nxt_d.idx  = cand_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign held     = cur_q.held;
    assign held_idx = cur_q.idx;

    // R8: latched number is frozen until released
    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !ack) |=> (held && $stable(held_idx)));
endmodule

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank #(
    parameter int N_LINES    = 32,
    parameter int PRIO_W     = 5,
    parameter int BANK_INDEX = 0,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] src_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               norm_irq,
    output logic               fast_irq
);
    import intc_pkg::*;

    localparam int IDX_W = $clog2(N_LINES);
    localparam int LVL_W = PRIO_W + 2;
    localparam int SRC_BASE = BANK_INDEX * N_LINES;

    typedef struct packed {
        logic [N_LINES-1:0]            mask;
        logic [N_LINES-1:0]            pend;
        logic [N_LINES-1:0]            prev;
        logic                          gate;
        logic [N_LINES-1:0][LVL_W-1:0] lvl;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic                           fast_ok;
    logic [N_LINES-1:0]             trig_lvl, route_fast, active;
    logic [N_LINES-1:0][PRIO_W-1:0] prio;
    logic                           n_found, f_found, n_held, f_held;
    logic [IDX_W-1:0]               n_win, f_win, n_idx, f_idx;
    logic                           wr_pend, wr_mask, wr_gate, ack_n, ack_f;
    logic                           is_lvl;
    logic [ADDR_W-1:0]              lvl_off;
    logic [IDX_W-1:0]               lidx;
    logic                           p;

    // Fast routing exists only in the first bank
    generate
        if (BANK_INDEX == 0) begin : g_fast_on
            assign fast_ok = 1'b1;
        end else begin : g_fast_off
            assign fast_ok = 1'b0;
        end
    endgenerate

    genvar gi;
    generate
        for (gi = 0; gi < N_LINES; gi++) begin : g_line
            assign trig_lvl[gi]   = cur_q.lvl[gi][CFG_LEVEL];
            assign route_fast[gi] = cur_q.lvl[gi][CFG_FAST];
            assign prio[gi]       = cur_q.lvl[gi][CFG_PRIO +: PRIO_W];
        end
    endgenerate

    assign active = cur_q.pend & ~cur_q.mask;

    // Bus decode
    assign wr_pend = bus_wr && (bus_addr == ADDR_W'(OFF_PEND));
    assign wr_mask = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
    assign wr_gate = bus_wr && (bus_addr == ADDR_W'(OFF_GATE));
    assign ack_n   = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[ACK_NORM];
    assign ack_f   = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[ACK_FAST];
    assign lvl_off = bus_addr - ADDR_W'(OFF_LVL);
    assign lidx    = lvl_off[IDX_W+1:2];
    assign is_lvl  = (bus_addr >= ADDR_W'(OFF_LVL)) && (lvl_off[1:0] == 2'b00)
                     && (int'(lvl_off >> 2) < N_LINES);

    intc_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_arb_norm (
        .req(active & ~route_fast), .prio(prio), .found(n_found), .win_idx(n_win));
    intc_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_arb_fast (
        .req(active & route_fast), .prio(prio), .found(f_found), .win_idx(f_win));

    intc_channel #(.IDX_W(IDX_W)) u_ch_norm (
        .clk(clk), .rst_n(rst_n), .ack(ack_n), .cand_ok(n_found),
        .cand_idx(n_win), .held(n_held), .held_idx(n_idx));
    intc_channel #(.IDX_W(IDX_W)) u_ch_fast (
        .clk(clk), .rst_n(rst_n), .ack(ack_f), .cand_ok(f_found),
        .cand_idx(f_win), .held(f_held), .held_idx(f_idx));

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = src_in;
        p          = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (trig_lvl[i]) begin
                nxt_d.pend[i] = src_in[i];
            end else begin
                p = cur_q.pend[i];
                if (wr_pend) p = p & bus_wdata[i];
                if (ack_n && n_held && n_idx == IDX_W'(i)) p = 1'b0;
                if (ack_f && f_held && f_idx == IDX_W'(i)) p = 1'b0;
                if (src_in[i] && !cur_q.prev[i]) p = 1'b1;
                nxt_d.pend[i] = p;
            end
        end
        if (wr_mask) nxt_d.mask = bus_wdata[N_LINES-1:0];
        if (wr_gate) nxt_d.gate = bus_wdata[0];
        if (bus_wr && is_lvl)
            nxt_d.lvl[lidx] = {bus_wdata[LVL_W-1:1], bus_wdata[CFG_FAST] & fast_ok};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.mask <= '1;
            cur_q.gate <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign norm_irq = n_held && active[n_idx] && !cur_q.gate;
    assign fast_irq = f_held && active[f_idx] && !cur_q.gate;

    always_comb begin
        bus_rdata = '0;
        if (is_lvl) begin
            bus_rdata[LVL_W-1:0] = cur_q.lvl[lidx];
        end else begin
            case (bus_addr)
                ADDR_W'(OFF_PEND): bus_rdata[N_LINES-1:0] = cur_q.pend;
                ADDR_W'(OFF_MASK): bus_rdata[N_LINES-1:0] = cur_q.mask;
                ADDR_W'(OFF_GATE): bus_rdata[0] = cur_q.gate;
                ADDR_W'(OFF_NSRC): if (n_held) bus_rdata = DATA_W'(SRC_BASE + int'(n_idx));
                ADDR_W'(OFF_FSRC): if (f_held) bus_rdata = DATA_W'(SRC_BASE + int'(f_idx));
                default: bus_rdata = '0;
            endcase
        end
    end

    // R2: a request never names a masked line
    assert_req_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_irq |-> !cur_q.mask[n_idx]) and (fast_irq |-> !cur_q.mask[f_idx]));

    // R10: nothing active means both outputs quiet
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (!norm_irq && !fast_irq));

    // R5: level lines track the input one cycle late
    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((cur_q.pend ^ $past(src_in)) & $past(trig_lvl)) == '0));

    // R4: non-zero banks never raise the fast output
    generate
        if (BANK_INDEX != 0) begin : g_chk_nofast
            assert_no_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !fast_irq);
        end
    endgenerate
endmodule

// File: tb/tb_intc_bank.sv
`timescale 1ns/1ps
module tb_intc_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [31:0] src_b1 = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rd_b1;
    logic        norm_irq, fast_irq, nirq_b1, firq_b1;

    always #10 clk = ~clk; // 50 MHz

    intc_bank dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .norm_irq(norm_irq), .fast_irq(fast_irq));

    intc_bank #(.BANK_INDEX(1)) dut_b1 (
        .clk(clk), .rst_n(rst_n), .src_in(src_b1), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b1),
        .norm_irq(nirq_b1), .fast_irq(firq_b1));

    localparam logic [7:0] A_PEND = 8'h00, A_MASK = 8'h04, A_NSRC = 8'h08,
                           A_FSRC = 8'h0C, A_CTRL = 8'h10, A_GATE = 8'h14;
    function automatic logic [7:0] a_lvl(input int line);
        return 8'(8'h80 + 4 * line);
    endfunction

    typedef struct {
        int          kind;   // 0 bank0 read, 1 bank0 outputs {fast,norm}, 2 bank1 read
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t exp_q[$];
    event  chk_ev;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;

    // Monitor: pops expected items and compares against the design
    always @(chk_ev) begin
        while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = {30'd0, fast_irq, norm_irq};
                default: act = rd_b1;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h (addr 0x%02h)",
                         it.req, act, it.exp, bus_addr);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic push(input int kind, input logic [7:0] a,
                        input logic [31:0] e, input string req);
        item_t it;
        bus_addr = a;
        #1;
        it.kind = kind; it.exp = e; it.req = req;
        exp_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string req);
        push(0, a, e, req);
    endtask
    task automatic chk_irq(input logic [1:0] e, input string req);
        push(1, bus_addr, {30'd0, e}, req);
    endtask
    task automatic chk_b1(input logic [7:0] a, input logic [31:0] e, input string req);
        push(2, a, e, req);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    localparam logic [31:0] M1 = 32'hFFEFFB77; // lines 3,7,10,20 unmasked
    localparam logic [31:0] M1_5 = 32'hFFEFFB57; // plus line 5
    localparam logic [31:0] M2 = 32'hFFEFFBD7; // line 7 masked, 5 open

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk_rd(A_MASK, 32'hFFFFFFFF, "R1 mask reset");
        chk_rd(A_GATE, 32'h1, "R1 gate reset");
        chk_irq(2'b00, "R1 outputs reset");
        chk_rd(A_NSRC, 32'h0, "R1 nsrc reset");
        step(1);

        // R3 configuration
        wr(a_lvl(3),  32'h14);   // prio 5 edge
        wr(a_lvl(7),  32'h08);   // prio 2 edge
        wr(a_lvl(10), 32'h08);   // prio 2 edge
        wr(a_lvl(5),  32'h02);   // prio 0 level
        wr(a_lvl(20), 32'h07);   // prio 1 level fast
        chk_rd(a_lvl(20), 32'h07, "R3 config readback");
        chk_b1(a_lvl(20), 32'h06, "R4 fast bit forced in bank 1");
        wr(A_MASK, M1);
        wr(A_GATE, 32'h0);

        // R7 priority beats index
        src_in[3] = 1'b1; src_in[10] = 1'b1;
        step(2);
        chk_irq(2'b01, "R7 normal request");
        chk_rd(A_NSRC, 32'd10, "R7 lower prio value wins");
        chk_rd(A_PEND, 32'h0000_0408, "R5 edge pending set");
        // R8 freeze on later arrival
        src_in[7] = 1'b1;
        step(3);
        chk_rd(A_NSRC, 32'd10, "R8 frozen during service");
        wr(A_CTRL, 32'h1);
        chk_irq(2'b00, "R8 gap after acknowledge");
        chk_rd(A_PEND, 32'h0000_0088, "R5 ack clears edge pending");
        step(1);
        chk_rd(A_NSRC, 32'd7, "R8 next winner");
        wr(A_CTRL, 32'h1);
        step(1);
        chk_rd(A_NSRC, 32'd3, "R7 remaining source");
        wr(A_CTRL, 32'h1);
        step(1);
        chk_irq(2'b00, "R10 nothing active");
        chk_rd(A_NSRC, 32'd0, "R9 none held reads 0");
        chk_rd(A_PEND, 32'h0, "R5 steady high not re-armed");

        // R7 tie on equal priority
        src_in[3] = 1'b0; src_in[7] = 1'b0; src_in[10] = 1'b0;
        step(1);
        src_in[7] = 1'b1; src_in[10] = 1'b1;
        step(2);
        chk_rd(A_NSRC, 32'd7, "R7 tie lower index");
        wr(A_CTRL, 32'h1);
        step(1);
        chk_rd(A_NSRC, 32'd10, "R7 tie second");
        wr(A_CTRL, 32'h1);
        step(1);
        chk_irq(2'b00, "R8 all released");
        src_in[7] = 1'b0; src_in[10] = 1'b0;

        // R2 masking, R5 level
        src_in[5] = 1'b1;
        step(2);
        chk_rd(A_PEND, 32'h20, "R2 masked line still pending");
        chk_irq(2'b00, "R2 masked line blocked");
        wr(A_MASK, M1_5);
        step(1);
        chk_rd(A_NSRC, 32'd5, "R2 unmasked line taken");
        chk_irq(2'b01, "R2 request after unmask");
        src_in[5] = 1'b0;
        step(1);
        chk_irq(2'b00, "R10 level source gone");
        chk_rd(A_NSRC, 32'd5, "R8 number kept until ack");
        wr(A_CTRL, 32'h1);
        step(1);

        // Fast path, independent acknowledge
        src_in[20] = 1'b1;
        step(2);
        chk_irq(2'b10, "R3 fast routing");
        chk_rd(A_FSRC, 32'd20, "R9 fast source number");
        chk_rd(A_NSRC, 32'd0, "R9 normal idle");
        wr(A_CTRL, 32'h1);
        chk_irq(2'b10, "R8 normal ack leaves fast");
        chk_rd(A_FSRC, 32'd20, "R8 fast still held");
        src_in[20] = 1'b0;
        wr(A_CTRL, 32'h2);
        step(1);
        chk_irq(2'b00, "R8 fast released");
        chk_rd(A_FSRC, 32'd0, "R9 fast none");

        // R10 global gate
        wr(A_GATE, 32'h1);
        src_in[3] = 1'b1;
        step(3);
        chk_irq(2'b00, "R10 gate blocks");
        chk_rd(A_PEND, 32'h8, "R10 pending while gated");
        wr(A_GATE, 32'h0);
        chk_irq(2'b01, "R10 gate opened");
        chk_rd(A_NSRC, 32'd3, "R10 source after gate");
        wr(A_CTRL, 32'h1);
        src_in[3] = 1'b0;
        step(1);
        chk_irq(2'b00, "R10 quiet after ack");

        // R6 pending clear by write
        wr(A_MASK, M2);
        src_in[7] = 1'b1;
        step(2);
        chk_rd(A_PEND, 32'h80, "R6 pending before clear");
        wr(A_PEND, 32'h0);
        chk_rd(A_PEND, 32'h0, "R6 pending cleared");
        wr(A_MASK, M1);
        step(2);
        chk_irq(2'b00, "R6 cleared line not requested");
        chk_rd(A_NSRC, 32'd0, "R6 nothing latched");
        src_in[7] = 1'b0;

        // R9 bank offset numbering
        src_b1[10] = 1'b1;
        step(2);
        chk_b1(A_NSRC, 32'd42, "R9 bank 1 global number");
        step(2);
        done = 1'b1;
        finish_run();
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end
endmodule